// File: doc/BRIEF.md
# Bit-Manipulation Execute Unit

This unit sits in the execute stage of a 32-bit RISC-V core. It produces the results of the address-generation, basic bit-manipulation and single-bit instruction groups. The decoder supplies an operation code and two operands. Operand A is the rs1 value. Operand B is either the rs2 value or the 5-bit immediate, which the decoder has already zero-extended. The result is written to rd. The immediate rotate uses the same rotate-right code as the register form; only the source of operand B differs.

All results are computed combinationally in one pass. They are captured in a single output register, so a request presented on one clock edge appears at the outputs after that edge. A valid flag travels alongside the result. When no request is presented, the last result stays on the output.

Top module: `bmu_exec`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` equals the `in_valid` sampled at the previous clock edge. `result` takes the new value only on an edge where `in_valid` is 1; otherwise it keeps its previous value.
- R3: Codes 0, 1 and 2 return B + (A << 1), B + (A << 2) and B + (A << 3) respectively, modulo 2^32.
- R4: Code 3 returns A & ~B, code 4 returns A | ~B and code 5 returns ~(A ^ B).
- R5: Code 6 counts the leading zeros of A and code 7 counts the trailing zeros of A; both return 32 when A is 0. Code 8 returns the number of set bits in A, from 0 to 32.
- R6: Code 9 returns the signed maximum of A and B, code 10 the unsigned maximum, code 11 the signed minimum and code 12 the unsigned minimum.
- R7: Code 13 sign-extends A[7:0], code 14 sign-extends A[15:0] and code 15 zero-extends A[15:0].
- R8: Code 16 rotates A left and code 17 rotates A right, each by B[4:0]. B[31:5] is ignored, and a rotate amount of 0 returns A.
- R9: Code 18 sets each result byte to 0xFF if the matching byte of A is nonzero, and to 0x00 otherwise. Code 19 returns A with its four bytes in reverse order.
- R10: With n = B[4:0], code 20 returns A with bit n set, code 21 returns A with bit n cleared, code 22 returns A with bit n inverted, and code 23 returns A[n] in bit 0 with all other bits 0.
- R11: Codes 24 through 31 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_sel | input | 5 | Operation code (see requirements) |
| opnd_a | input | 32 | Operand A (rs1 value) |
| opnd_b | input | 32 | Operand B (rs2 value or zero-extended immediate) |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 32 | Registered result for rd |

## Verification
Every one of the 32 codes is driven with each pairing of the four corner values 0, all-ones, 0x80000000 and 0x7FFFFFFF.

- The pairing with 0 exposes an off-by-one in the counters when A is 0, and shows whether a rotate by zero returns A unchanged.
- All-ones as operand B is a bit index of 31 with every upper bit set, so it catches rotates and single-bit operations that fail to mask B down to its low five bits.
- 0x80000000 against 0x7FFFFFFF separates a signed comparison from an unsigned one.

Random operands then vary the bit indices, rotate amounts and byte patterns. Idle cycles with changing operands are mixed in to show that the result register holds its value.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
    localparam int XLEN_DEF = 32;

    typedef enum logic [4:0] {
        OP_SH1ADD = 5'd0,
        OP_SH2ADD = 5'd1,
        OP_SH3ADD = 5'd2,
        OP_ANDN   = 5'd3,
        OP_ORN    = 5'd4,
        OP_XNOR   = 5'd5,
        OP_CLZ    = 5'd6,
        OP_CTZ    = 5'd7,
        OP_CPOP   = 5'd8,
        OP_MAX    = 5'd9,
        OP_MAXU   = 5'd10,
        OP_MIN    = 5'd11,
        OP_MINU   = 5'd12,
        OP_SEXTB  = 5'd13,
        OP_SEXTH  = 5'd14,
        OP_ZEXTH  = 5'd15,
        OP_ROL    = 5'd16,
        OP_ROR    = 5'd17,
        OP_ORCB   = 5'd18,
        OP_REV8   = 5'd19,
        OP_BSET   = 5'd20,
        OP_BCLR   = 5'd21,
        OP_BINV   = 5'd22,
        OP_BEXT   = 5'd23
    } bmu_op_e;
endpackage

// File: rtl/bmu_count.sv
module bmu_count #(
    parameter int XLEN = 32,
    localparam int CW = $clog2(XLEN) + 1
) (
    input  logic [XLEN-1:0] a,
    output logic [CW-1:0]   lead,
    output logic [CW-1:0]   trail,
    output logic [CW-1:0]   ones
);
    logic seen_hi;
    logic seen_lo;

    // Leading zeros: scan from the top bit down to the first set bit.
    always_comb begin
        lead    = CW'(XLEN);
        seen_hi = 1'b0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (!seen_hi && a[i]) begin
                lead    = CW'(XLEN - 1 - i);
                seen_hi = 1'b1;
            end
        end
    end

    // Trailing zeros: scan from bit 0 up to the first set bit.
    always_comb begin
        trail   = CW'(XLEN);
        seen_lo = 1'b0;
        for (int i = 0; i < XLEN; i++) begin
            if (!seen_lo && a[i]) begin
                trail   = CW'(i);
                seen_lo = 1'b1;
            end
        end
    end

    // Population count.
    always_comb begin
        ones = '0;
        for (int i = 0; i < XLEN; i++) begin
            ones = ones + CW'(a[i]);
        end
    end
endmodule

// File: rtl/bmu_perm.sv
module bmu_perm #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN),
    localparam int NB  = XLEN / 8
) (
    input  logic [XLEN-1:0] a,
    input  logic [SHW-1:0]  amt,
    output logic [XLEN-1:0] rot_l,
    output logic [XLEN-1:0] rot_r,
    output logic [XLEN-1:0] byte_or,
    output logic [XLEN-1:0] byte_rev
);
    logic [2*XLEN-1:0] dbl_l;
    logic [2*XLEN-1:0] dbl_r;

    // Shifting a doubled copy of A gives the rotate with no wrap logic.
    assign dbl_l = {a, a} << amt;
    assign dbl_r = {a, a} >> amt;
    assign rot_l = dbl_l[2*XLEN-1:XLEN];
    assign rot_r = dbl_r[XLEN-1:0];

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign byte_or[8*g +: 8]  = {8{|a[8*g +: 8]}};
        assign byte_rev[8*g +: 8] = a[8*(NB-1-g) +: 8];
    end
endmodule

// File: rtl/bmu_arith.sv
module bmu_arith #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] sh1,
    output logic [XLEN-1:0] sh2,
    output logic [XLEN-1:0] sh3,
    output logic [XLEN-1:0] max_s,
    output logic [XLEN-1:0] max_u,
    output logic [XLEN-1:0] min_s,
    output logic [XLEN-1:0] min_u
);
    logic lt_s;
    logic lt_u;

    assign sh1 = b + (a << 1);
    assign sh2 = b + (a << 2);
    assign sh3 = b + (a << 3);

    // One signed and one unsigned comparator serve all four min/max codes.
    assign lt_s  = $signed(a) < $signed(b);
    assign lt_u  = a < b;
    assign max_s = lt_s ? b : a;
    assign min_s = lt_s ? a : b;
    assign max_u = lt_u ? b : a;
    assign min_u = lt_u ? a : b;
endmodule

// File: rtl/bmu_bitlogic.sv
module bmu_bitlogic #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] and_inv,
    output logic [XLEN-1:0] or_inv,
    output logic [XLEN-1:0] xor_inv,
    output logic [XLEN-1:0] sx_byte,
    output logic [XLEN-1:0] sx_half,
    output logic [XLEN-1:0] zx_half,
    output logic [XLEN-1:0] bit_set,
    output logic [XLEN-1:0] bit_clr,
    output logic [XLEN-1:0] bit_flip,
    output logic [XLEN-1:0] bit_get
);
    logic [SHW-1:0]  idx;
    logic [XLEN-1:0] mask;

    assign and_inv = a & ~b;
    assign or_inv  = a | ~b;
    assign xor_inv = ~(a ^ b);

    assign sx_byte = {{(XLEN-8){a[7]}}, a[7:0]};
    assign sx_half = {{(XLEN-16){a[15]}}, a[15:0]};
    assign zx_half = {{(XLEN-16){1'b0}}, a[15:0]};

    // Only the low log2(XLEN) bits of B select the bit.
    assign idx      = b[SHW-1:0];
    assign mask     = {{(XLEN-1){1'b0}}, 1'b1} << idx;
    assign bit_set  = a | mask;
    assign bit_clr  = a & ~mask;
    assign bit_flip = a ^ mask;
    assign bit_get  = {{(XLEN-1){1'b0}}, a[idx]};
endmodule

// File: rtl/bmu_exec.sv
module bmu_exec #(
    parameter int XLEN = bmu_pkg::XLEN_DEF,
    localparam int SHW = $clog2(XLEN),
    localparam int CW  = SHW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [4:0]      op_sel,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic            out_valid,
    output logic [XLEN-1:0] result
);
    import bmu_pkg::*;

    bmu_op_e op;
    assign op = bmu_op_e'(op_sel);

    logic [CW-1:0]   cnt_lead, cnt_trail, cnt_ones;
    logic [XLEN-1:0] rot_l, rot_r, byte_or, byte_rev;
    logic [XLEN-1:0] sh1, sh2, sh3, max_s, max_u, min_s, min_u;
    logic [XLEN-1:0] and_inv, or_inv, xor_inv, sx_byte, sx_half, zx_half;
    logic [XLEN-1:0] bit_set, bit_clr, bit_flip, bit_get;
    logic [XLEN-1:0] nxt_result;

    bmu_count #(.XLEN(XLEN)) u_count (
        .a     (opnd_a),
        .lead  (cnt_lead),
        .trail (cnt_trail),
        .ones  (cnt_ones)
    );

    bmu_perm #(.XLEN(XLEN)) u_perm (
        .a        (opnd_a),
        .amt      (opnd_b[SHW-1:0]),
        .rot_l    (rot_l),
        .rot_r    (rot_r),
        .byte_or  (byte_or),
        .byte_rev (byte_rev)
    );

    bmu_arith #(.XLEN(XLEN)) u_arith (
        .a     (opnd_a),
        .b     (opnd_b),
        .sh1   (sh1),
        .sh2   (sh2),
        .sh3   (sh3),
        .max_s (max_s),
        .max_u (max_u),
        .min_s (min_s),
        .min_u (min_u)
    );

    bmu_bitlogic #(.XLEN(XLEN)) u_bitlogic (
        .a        (opnd_a),
        .b        (opnd_b),
        .and_inv  (and_inv),
        .or_inv   (or_inv),
        .xor_inv  (xor_inv),
        .sx_byte  (sx_byte),
        .sx_half  (sx_half),
        .zx_half  (zx_half),
        .bit_set  (bit_set),
        .bit_clr  (bit_clr),
        .bit_flip (bit_flip),
        .bit_get  (bit_get)
    );

    // Result select: unused codes produce zero.
    always_comb begin
        unique case (op)
            OP_SH1ADD: nxt_result = sh1;
            OP_SH2ADD: nxt_result = sh2;
            OP_SH3ADD: nxt_result = sh3;
            OP_ANDN:   nxt_result = and_inv;
            OP_ORN:    nxt_result = or_inv;
            OP_XNOR:   nxt_result = xor_inv;
            OP_CLZ:    nxt_result = XLEN'(cnt_lead);
            OP_CTZ:    nxt_result = XLEN'(cnt_trail);
            OP_CPOP:   nxt_result = XLEN'(cnt_ones);
            OP_MAX:    nxt_result = max_s;
            OP_MAXU:   nxt_result = max_u;
            OP_MIN:    nxt_result = min_s;
            OP_MINU:   nxt_result = min_u;
            OP_SEXTB:  nxt_result = sx_byte;
            OP_SEXTH:  nxt_result = sx_half;
            OP_ZEXTH:  nxt_result = zx_half;
            OP_ROL:    nxt_result = rot_l;
            OP_ROR:    nxt_result = rot_r;
            OP_ORCB:   nxt_result = byte_or;
            OP_REV8:   nxt_result = byte_rev;
            OP_BSET:   nxt_result = bit_set;
            OP_BCLR:   nxt_result = bit_clr;
            OP_BINV:   nxt_result = bit_flip;
            OP_BEXT:   nxt_result = bit_get;
            default:   nxt_result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nxt_result;
            end
        end
    end
endmodule

// File: rtl/bmu_exec_chk.sv
module bmu_exec_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [4:0]      op_sel,
    input logic            out_valid,
    input logic [XLEN-1:0] result
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R5
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == 5'd6 || op_sel == 5'd7 || op_sel == 5'd8))
        |=> (result <= XLEN'(XLEN)));

    // R7
    sext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 5'd13) |=> (result[XLEN-1:8] == {(XLEN-8){result[7]}}));

    // R10
    bit_extract_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 5'd23) |=> (result[XLEN-1:1] == '0));

    // R11
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel >= 5'd24) |=> (result == '0));
endmodule

bind bmu_exec bmu_exec_chk #(.XLEN(XLEN)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/test_bmu_exec.sv
module test_bmu_exec;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        out_valid;
    logic [31:0] result;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Model state
    bit          exp_valid = 0;
    logic [31:0] exp_result = '0;
    string       exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    bmu_exec i_bmu_exec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
    );

    function automatic string tag_of(int op);
        if (op < 3)  return "R3";
        if (op < 6)  return "R4";
        if (op < 9)  return "R5";
        if (op < 13) return "R6";
        if (op < 16) return "R7";
        if (op < 18) return "R8";
        if (op < 20) return "R9";
        if (op < 24) return "R10";
        return "R11";
    endfunction

    function automatic logic [31:0] ref_calc(int op, logic [31:0] a, logic [31:0] b);
        logic [31:0] r = '0;
        int k = 0;
        int s = int'(b % 32);
        case (op)
            0:  r = b + a * 2;
            1:  r = b + a * 4;
            2:  r = b + a * 8;
            3:  r = a & ~b;
            4:  r = a | ~b;
            5:  r = ~(a ^ b);
            6:  begin while (k < 32 && a[31-k] == 1'b0) k++; r = k; end
            7:  begin while (k < 32 && a[k] == 1'b0) k++; r = k; end
            8:  begin for (int i = 0; i < 32; i++) if (a[i]) k++; r = k; end
            9:  r = ($signed(a) > $signed(b)) ? a : b;
            10: r = (a > b) ? a : b;
            11: r = ($signed(a) < $signed(b)) ? a : b;
            12: r = (a < b) ? a : b;
            13: r = a[7]  ? (32'hFFFFFF00 | (a & 32'hFF))   : (a & 32'hFF);
            14: r = a[15] ? (32'hFFFF0000 | (a & 32'hFFFF)) : (a & 32'hFFFF);
            15: r = a & 32'hFFFF;
            16: for (int i = 0; i < 32; i++) r[(i + s) % 32] = a[i];
            17: for (int i = 0; i < 32; i++) r[i] = a[(i + s) % 32];
            18: for (int j = 0; j < 4; j++) r[8*j +: 8] = (a[8*j +: 8] != 0) ? 8'hFF : 8'h00;
            19: for (int j = 0; j < 4; j++) r[8*j +: 8] = a[8*(3-j) +: 8];
            20: r = a | (32'd1 << s);
            21: r = a & ~(32'd1 << s);
            22: r = a ^ (32'd1 << s);
            23: r = (a >> s) & 32'd1;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic compare_now();
        n_cmp++;
        if (out_valid !== exp_valid) begin
            n_bad++;
            $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
        end
        n_cmp++;
        if (result !== exp_result) begin
            n_bad++;
            $display("FAIL %s result actual=%08h expected=%08h", exp_tag, result, exp_result);
        end
    endtask

    // Check the previous cycle's outcome, then drive the next request.
    task automatic apply(bit v, int op, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        compare_now();
        in_valid = v;
        op_sel   = 5'(op);
        opnd_a   = a;
        opnd_b   = b;
        exp_valid = v;
        if (v) begin
            exp_result = ref_calc(op, a, b);
            exp_tag    = tag_of(op);
        end else begin
            exp_tag = "R2";
        end
    endtask

    initial begin
        logic [31:0] corners [4];
        corners[0] = 32'h0000_0000;
        corners[1] = 32'hFFFF_FFFF;
        corners[2] = 32'h8000_0000;
        corners[3] = 32'h7FFF_FFFF;

        // R1: reset state, with inputs active during reset
        in_valid = 1'b1; op_sel = 5'd5; opnd_a = 32'h1234; opnd_b = 32'h5678;
        repeat (3) @(negedge clk);
        exp_tag = "R1";
        compare_now();
        in_valid = 1'b0;
        rst_n = 1'b1;

        // Corner pairs for every code
        for (int op = 0; op < 32; op++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    apply(1, op, corners[i], corners[j]);

        // R8: a rotate by 0 with upper B bits set must return A
        apply(1, 16, 32'hA5C3_0F96, 32'hFFFF_FFE0);
        apply(1, 17, 32'hA5C3_0F96, 32'h0000_0020);

        // Random operands, with idle cycles between (R2 hold)
        for (int n = 0; n < 40; n++) begin
            for (int op = 0; op < 32; op++) begin
                apply(1, op, $urandom, $urandom);
                if ((op % 5) == 0) apply(0, op, $urandom, $urandom);
            end
        end

        apply(0, 0, 32'h0, 32'h0);
        apply(0, 0, 32'h0, 32'h0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule